// File: doc/BRIEF.md
# Atomic Bit-Operation Register Bank

This block holds a parameterised number of control words behind a simple single-cycle memory-mapped port. Every word owns a 16-byte address slot. Inside that slot, address bits 3:2 pick how a write combines with the stored value: it can replace the word, OR bits into it, clear the bits that are one in the write data, or invert them. Software can therefore change individual bits without a read-modify-write sequence and without locking against other agents that share the word.

All four aliases of a slot read back the same stored word. Reads are registered: the data appears in the cycle after the request. Any request that is not an aligned 32-bit access, or that falls past the last slot, changes nothing and raises a one-cycle error pulse in the cycle after the request. Reset clears every word.

Top module: `atomic_reg_bank`

## Requirements
- R1: After reset every stored word is zero, and `rsp_rdata` and `rsp_err` are low.
- R2: The word index is byte address bits `ADDR_W-1:4`; word k occupies byte addresses 16k to 16k+15, and the last word (index `NUM_REGS-1`) is reachable.
- R3: A legal write with address bits 3:2 equal to 0 (offset 0x0) replaces the word with `req_wdata`.
- R4: A legal write with address bits 3:2 equal to 1 (offset 0x4) stores word OR `req_wdata`.
- R5: A legal write with address bits 3:2 equal to 2 (offset 0x8) stores word AND NOT `req_wdata`.
- R6: A legal write with address bits 3:2 equal to 3 (offset 0xC) stores word XOR `req_wdata`.
- R7: A legal read at any of the four offsets returns the stored word on `rsp_rdata` in the cycle after `req_rd`; in a cycle after no read request, `rsp_rdata` is zero.
- R8: Only `req_size` = 2'b10 (4 bytes; 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b11 = 8 bytes) with address bits 1:0 equal to zero is legal; any other request writes nothing, reads as zero and sets `rsp_err` for the next cycle.
- R9: A request whose index is `NUM_REGS` or above writes nothing, reads as zero and sets `rsp_err` for the next cycle.
- R10: A read in the same cycle as a write to the same word returns the value before the write; a read in any later cycle returns the updated value.
- R11: `rsp_err` is high in a cycle only if the previous cycle carried an illegal request; legal requests and idle cycles leave it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Access size code, 2'b10 means 32-bit |
| req_wr | input | 1 | Write request |
| req_wdata | input | DATA_W | Write data / bit mask |
| req_rd | input | 1 | Read request |
| rsp_rdata | output | DATA_W | Registered read data |
| rsp_err | output | 1 | One-cycle error pulse for an illegal request |

## Verification
The hardest case to reach is a read and a write to the same word in one cycle, where the read must observe the old value while the bit operation lands one edge later. The random stimulus draws reads and writes independently on a small index range, so coincident accesses to one word arise often, and a directed pair exercises it with each of the four offsets. Out-of-range and illegal-size requests are mixed in to show they leave the stored words untouched, confirmed by a final sweep that reads every word.

// File: rtl/srt_pkg.sv
package srt_pkg;

   // Write behaviour selected by byte address bits 3:2
   typedef enum logic [1:0] {
      OP_PLAIN = 2'd0,
      OP_SET   = 2'd1,
      OP_CLR   = 2'd2,
      OP_TOG   = 2'd3
   } srt_op_e;

   // Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes
   localparam logic [1:0] SIZE_WORD = 2'b10;

   // Address bits consumed inside one slot
   localparam int SLOT_BITS = 4;

endpackage

// File: rtl/srt_decode.sv
module srt_decode
   import srt_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int NUM_REGS = 8,
   localparam int IDX_W   = ADDR_W - SLOT_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              wr,
   input  logic              rd,
   output logic [IDX_W-1:0]  idx,
   output srt_op_e           op,
   output logic              wr_go,
   output logic              rd_go,
   output logic              bad
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

   logic aligned;
   logic is_word;
   logic in_range;
   logic legal;

   always_comb begin
      idx      = addr[ADDR_W-1:SLOT_BITS];
      op       = srt_op_e'(addr[3:2]);
      aligned  = (addr[1:0] == 2'b00);
      is_word  = (size == SIZE_WORD);
      in_range = (idx <= LAST_IDX);
      legal    = aligned && is_word && in_range;
      wr_go    = wr && legal;
      rd_go    = rd && legal;
      bad      = (wr || rd) && !legal;
   end

endmodule

// File: rtl/srt_cell.sv
module srt_cell
   import srt_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit ASYNC_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  srt_op_e           op,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] nxt;

   always_comb begin
      unique case (op)
         OP_PLAIN: nxt = mask;
         OP_SET:   nxt = q | mask;
         OP_CLR:   nxt = q & ~mask;
         OP_TOG:   nxt = q ^ mask;
         default:  nxt = q;
      endcase
   end

   if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (upd) q <= nxt;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n)   q <= '0;
         else if (upd) q <= nxt;
      end
   end

endmodule

// File: rtl/srt_rdmux.sv
module srt_rdmux #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 8
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] words,
   input  logic [IDX_W-1:0]                idx,
   input  logic                            rd_go,
   output logic [DATA_W-1:0]               dout
);

   logic [NUM_REGS-1:0] hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      assign hit[i] = rd_go && (idx == IDX_W'(i));
   end

   // AND-OR selection: zero when nothing is selected
   always_comb begin
      dout = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         dout = dout | (words[i] & {DATA_W{hit[i]}});
      end
   end

endmodule

// File: rtl/atomic_reg_bank.sv
module atomic_reg_bank
   import srt_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NUM_REGS    = 8,
   parameter int ADDR_W      = 12,
   parameter bit ASYNC_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_wr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_rd,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);

   localparam int IDX_W = ADDR_W - SLOT_BITS;

   // Elaboration-time parameter checks
   if (NUM_REGS < 1) begin : g_bad_num
      $error("atomic_reg_bank: NUM_REGS must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("atomic_reg_bank: DATA_W must be at least 1");
   end
   if (IDX_W < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_addr
      $error("atomic_reg_bank: ADDR_W too small for NUM_REGS slots");
   end

   logic [IDX_W-1:0]                idx;
   srt_op_e                         op;
   logic                            wr_go;
   logic                            rd_go;
   logic                            bad;
   logic [NUM_REGS-1:0][DATA_W-1:0] words;
   logic [DATA_W-1:0]               rd_next;

   srt_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_REGS(NUM_REGS)
   ) i_decode (
      .addr (req_addr),
      .size (req_size),
      .wr   (req_wr),
      .rd   (req_rd),
      .idx  (idx),
      .op   (op),
      .wr_go(wr_go),
      .rd_go(rd_go),
      .bad  (bad)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      logic upd;
      assign upd = wr_go && (idx == IDX_W'(i));
      srt_cell #(
         .DATA_W     (DATA_W),
         .ASYNC_RESET(ASYNC_RESET)
      ) i_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .upd  (upd),
         .op   (op),
         .mask (req_wdata),
         .q    (words[i])
      );
   end

   srt_rdmux #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .IDX_W   (IDX_W)
   ) i_rdmux (
      .words(words),
      .idx  (idx),
      .rd_go(rd_go),
      .dout (rd_next)
   );

   if (ASYNC_RESET) begin : g_out_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
         end else begin
            rsp_rdata <= rd_next;
            rsp_err   <= bad;
         end
      end
   end else begin : g_out_sync
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
         end else begin
            rsp_rdata <= rd_next;
            rsp_err   <= bad;
         end
      end
   end

endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 8,
   parameter int ADDR_W   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              req_wr,
   input logic              req_rd,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_err
);

   localparam int IDX_W = ADDR_W - 4;

   logic req_ok;
   assign req_ok = (req_size == 2'b10) && (req_addr[1:0] == 2'b00)
                   && (int'(req_addr[ADDR_W-1:4]) < NUM_REGS);

   // R7: no read request, no read data
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_rd) |-> (rsp_rdata == '0));

   // R8 / R9: an illegal read returns zero
   p_bad_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_rd && !req_ok) |-> (rsp_rdata == '0));

   // R8 / R9: an illegal request raises the error flag next cycle
   p_bad_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past((req_wr || req_rd) && !req_ok) |-> rsp_err);

   // R11: error only after an illegal request
   p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past((req_wr || req_rd) && !req_ok));

   // R11: legal or idle cycle leaves error low
   p_legal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!((req_wr || req_rd) && !req_ok)) |-> !rsp_err);

   // R1: outputs are quiet during reset
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (rsp_err == 1'b0 || $isunknown(rsp_err));
      end
   end

   logic [IDX_W-1:0] unused_idx;
   assign unused_idx = req_addr[ADDR_W-1:4];

endmodule

bind atomic_reg_bank srt_checker #(
   .DATA_W  (DATA_W),
   .NUM_REGS(NUM_REGS),
   .ADDR_W  (ADDR_W)
) i_srt_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_addr (req_addr),
   .req_size (req_size),
   .req_wr   (req_wr),
   .req_rd   (req_rd),
   .rsp_rdata(rsp_rdata),
   .rsp_err  (rsp_err)
);

// File: tb/test_atomic_reg_bank.sv
module test_atomic_reg_bank;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 32;
   localparam int NUM_REGS   = 8;
   localparam int ADDR_W     = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [1:0]        req_size = 2'b10;
   logic              req_wr = 1'b0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              req_rd = 1'b0;
   logic [DATA_W-1:0] rsp_rdata;
   logic              rsp_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [DATA_W-1:0] model [NUM_REGS];

   always #(CLK_PERIOD/2) clk = ~clk;

   atomic_reg_bank #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .ADDR_W  (ADDR_W)
   ) i_atomic_reg_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_addr (req_addr),
      .req_size (req_size),
      .req_wr   (req_wr),
      .req_wdata(req_wdata),
      .req_rd   (req_rd),
      .rsp_rdata(rsp_rdata),
      .rsp_err  (rsp_err)
   );

   function automatic bit is_legal(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
      return (sz == 2'b10) && (a[1:0] == 2'b00) && (int'(a[ADDR_W-1:4]) < NUM_REGS);
   endfunction

   function automatic logic [DATA_W-1:0] apply_op(input logic [DATA_W-1:0] cur,
                                                  input logic [1:0] op,
                                                  input logic [DATA_W-1:0] d);
      case (op)
         2'd0:    return d;
         2'd1:    return cur | d;
         2'd2:    return cur & ~d;
         default: return cur ^ d;
      endcase
   endfunction

   task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                        input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One request cycle; outputs checked at the following negedge
   task automatic txn(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                      input logic w, input logic r, input logic [DATA_W-1:0] d,
                      input string tag);
      logic [DATA_W-1:0] exp_rd;
      logic              exp_err;
      bit                ok;
      int                k;
      ok      = is_legal(a, sz);
      k       = int'(a[ADDR_W-1:4]);
      exp_rd  = (r && ok) ? model[k] : '0;
      exp_err = (w || r) && !ok;
      req_addr  = a;
      req_size  = sz;
      req_wr    = w;
      req_rd    = r;
      req_wdata = d;
      if (w && ok) model[k] = apply_op(model[k], a[3:2], d);
      @(negedge clk);
      check(rsp_rdata, exp_rd, {tag, " rdata"});
      check({31'd0, rsp_err}, {31'd0, exp_err}, {tag, " err"});
      req_wr = 1'b0;
      req_rd = 1'b0;
   endtask

   task automatic idle(input string tag);
      txn('0, 2'b10, 1'b0, 1'b0, '0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(rsp_rdata, '0, "R1 reset rdata");
      check({31'd0, rsp_err}, 32'd0, "R1 reset err");
      rst_n = 1'b1;
      @(negedge clk);

      // R1: every word reads zero; R2 stride
      for (int i = 0; i < NUM_REGS; i++) txn(ADDR_W'(i * 16), 2'b10, 1'b0, 1'b1, '0, "R1 R2");

      // R3..R6 on word 0 and each alias read (R7)
      txn(12'h000, 2'b10, 1'b1, 1'b0, 32'hA5A5_0F0F, "R3");
      txn(12'h004, 2'b10, 1'b1, 1'b0, 32'h0000_F0F0, "R4");
      txn(12'h00C, 2'b10, 1'b0, 1'b1, '0, "R4 R7");
      txn(12'h008, 2'b10, 1'b1, 1'b0, 32'hA000_000F, "R5");
      txn(12'h008, 2'b10, 1'b0, 1'b1, '0, "R5 R7");
      txn(12'h00C, 2'b10, 1'b1, 1'b0, 32'hFFFF_0000, "R6");
      txn(12'h004, 2'b10, 1'b0, 1'b1, '0, "R6 R7");
      txn(12'h000, 2'b10, 1'b0, 1'b1, '0, "R7");
      idle("R7 idle");

      // R2: last word
      txn(ADDR_W'((NUM_REGS - 1) * 16), 2'b10, 1'b1, 1'b0, 32'h1234_5678, "R2");
      txn(ADDR_W'((NUM_REGS - 1) * 16 + 8), 2'b10, 1'b0, 1'b1, '0, "R2");

      // R10: same-cycle write+read returns old, next returns new
      for (int op = 0; op < 4; op++) begin
         txn(ADDR_W'(16 + op * 4), 2'b10, 1'b1, 1'b1, 32'h0F0F_3C3C, "R10 same");
         txn(12'h010, 2'b10, 1'b0, 1'b1, '0, "R10 after");
      end

      // R8: bad sizes and misalignment
      for (int s = 0; s < 4; s++) begin
         if (s != 2) txn(12'h020, 2'(s), 1'b1, 1'b1, 32'hDEAD_BEEF, "R8 size");
      end
      txn(12'h022, 2'b10, 1'b1, 1'b0, 32'hDEAD_BEEF, "R8 misalign");
      txn(12'h021, 2'b10, 1'b0, 1'b1, '0, "R8 misalign rd");
      txn(12'h020, 2'b10, 1'b0, 1'b1, '0, "R8 untouched");

      // R9: past the last slot
      txn(ADDR_W'(NUM_REGS * 16), 2'b10, 1'b1, 1'b0, 32'hFFFF_FFFF, "R9 wr");
      txn(ADDR_W'(NUM_REGS * 16), 2'b10, 1'b0, 1'b1, '0, "R9 rd");
      txn(12'hFF0, 2'b10, 1'b1, 1'b1, 32'h1111_1111, "R9 top");
      idle("R11 idle");

      // Constrained random mix
      for (int n = 0; n < 400; n++) begin
         logic [ADDR_W-1:0] a;
         logic [1:0]        sz;
         int                k;
         k  = int'($urandom % (NUM_REGS + 2));
         a  = ADDR_W'(k * 16) | ADDR_W'(($urandom % 4) * 4);
         if ($urandom % 16 == 0) a[1:0] = 2'($urandom % 4);
         sz = ($urandom % 12 == 0) ? 2'($urandom % 4) : 2'b10;
         txn(a, sz, 1'($urandom % 2), 1'($urandom % 2), $urandom,
             "rand R3 R4 R5 R6 R10 R11");
      end

      // Final sweep
      for (int i = 0; i < NUM_REGS; i++) txn(ADDR_W'(i * 16 + 4), 2'b10, 1'b0, 1'b1, '0, "R7 sweep");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule